// File: doc/BRIEF.md
# Spike Synapse Capture and Summation

This block is the input stage of a spiking neuron. It has a parameterised number of synaptic inputs, four by default. Each input takes a spike pulse whose timing is unrelated to the neuron clock, and each synapse holds one 6-bit two's complement weight.

A synapse brings its spike into the clock domain and detects its leading edge. It then marks the event pending, which places its weight on a shared summing node. The output register samples that node on the next rising clock edge, which consumes the event.

The registered output is the weight total for one neuron time step, clamped to the 6-bit signed range. The soma integrates this value downstream. Weights are loaded through a plain address/data/enable write port and are kept across reset.

Top module: `spk_syn_sum`

## Requirements
- R1: While `rst_n` is low, `sum_out` reads 0 and every captured spike event is discarded, so no event taken before reset appears after it. Stored weights are not changed by reset.
- R2: When `wr_en` is high at a rising edge, `wr_data` (6-bit two's complement) is stored as the weight of the synapse numbered `wr_addr`, and no other synapse's weight changes. All spikes sampled afterwards use the new weight.
- R3: A rising level on `spike_in[i]` first sampled at clock edge e0 sets the synapse's pending event at edge e0+SYNC_STAGES. Its weight appears in `sum_out` after edge e0+SYNC_STAGES+1, which is edge e3 by default, and stays there for exactly one cycle.
- R4: `sum_out` equals the sum of the weights of exactly those synapses whose events are sampled on the same edge. Synapses without an event add zero.
- R5: A true sum above +31 gives `sum_out` = +31, and a sum below -32 gives -32. The sum never wraps.
- R6: A spike input held high for many cycles produces one event. A further event needs the input to be sampled low for at least one cycle and then high again.
- R7: Spikes whose leading edges are sampled in different cycles are summed into different output cycles, in the same order.
- R8: When no synapse has a pending event, the next `sum_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Neuron clock; rising edge samples the summing node |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released on a clock boundary |
| spike_in | input | N_SYN | One spike line per synapse; asynchronous to clk, active high |
| wr_en | input | 1 | Weight write strobe |
| wr_addr | input | ADDR_W | Synapse index targeted by the write |
| wr_data | input | W_WIDTH | Weight value, two's complement |
| sum_out | output | W_WIDTH | Saturated signed weight sum for the current time step |

## Verification
Several properties are checked on every cycle:
- a pending event lasts one cycle;
- a level never produces edge detections on back-to-back cycles;
- an idle node yields zero;
- an out-of-range true sum lands on the right clamp;
- an in-range sum passes through unchanged;
- a write reaches exactly the addressed weight.

The bench scenarios show what no single-cycle property can: the end-to-end latency counted from the spike pin, and that a held line fires once but re-arms after a one-cycle low. They also show that staggered spikes separate into consecutive samples, that a reset drops an event already pending, and that the weights survive that reset.

// File: rtl/spk_syn_pkg.sv
package spk_syn_pkg;

  localparam int DEF_SYN   = 4;
  localparam int DEF_WIDTH = 6;
  localparam int DEF_SYNC  = 2;

  // Width that holds the exact sum of n signed w-bit terms plus headroom.
  function automatic int sum_width(input int n, input int w);
    return w + $clog2(n) + 1;
  endfunction

  function automatic int addr_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/spk_edge_sync.sv
module spk_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);

  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;

  always_comb begin
    sync_d[0] = async_in;
    for (int k = 1; k < STAGES; k++) begin
      sync_d[k] = sync_q[k-1];
    end
    prev_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  // Leading edge of the synchronised level: one cycle wide per low-to-high change.
  assign rise_o = sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/spk_syn_slot.sv
module spk_syn_slot #(
  parameter int W_WIDTH     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               spike_async,
  input  logic               wr_sel,
  input  logic [W_WIDTH-1:0] wr_data,
  output logic [W_WIDTH-1:0] weight_o,
  output logic               pending_o,
  output logic               rise_o,
  output logic [W_WIDTH-1:0] contrib_o
);

  logic               rise;
  logic               pending_q, pending_d;
  logic [W_WIDTH-1:0] weight_q;

  spk_edge_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(spike_async),
    .rise_o  (rise)
  );

  // The output register consumes the pending event on every edge. A new
  // leading edge in that same cycle re-arms the flag. A level held high yields
  // only one leading edge, so it merges into a single event.
  always_comb begin
    pending_d = rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
    end else begin
      pending_q <= pending_d;
    end
  end

  // Weight storage: loaded only through the write port, kept across reset.
  always_ff @(posedge clk) begin
    if (wr_sel) begin
      weight_q <= wr_data;
    end
  end

  assign contrib_o = pending_q ? weight_q : '0;
  assign weight_o  = weight_q;
  assign pending_o = pending_q;
  assign rise_o    = rise;

endmodule

// File: rtl/spk_sat_sum.sv
module spk_sat_sum #(
  parameter int N_SYN   = 4,
  parameter int W_WIDTH = 6,
  parameter int SUM_W   = 9
) (
  input  logic [N_SYN*W_WIDTH-1:0] contrib_flat,
  output logic signed [SUM_W-1:0]  raw_sum,
  output logic signed [W_WIDTH-1:0] sat_sum
);

  localparam logic signed [SUM_W-1:0] HI = SUM_W'((2 ** (W_WIDTH - 1)) - 1);
  localparam logic signed [SUM_W-1:0] LO = SUM_W'(-(2 ** (W_WIDTH - 1)));

  logic signed [SUM_W-1:0] ext [N_SYN];

  for (genvar i = 0; i < N_SYN; i++) begin : g_ext
    assign ext[i] = SUM_W'($signed(contrib_flat[i*W_WIDTH +: W_WIDTH]));
  end

  always_comb begin
    raw_sum = '0;
    for (int i = 0; i < N_SYN; i++) begin
      raw_sum = raw_sum + ext[i];
    end
  end

  always_comb begin
    if (raw_sum > HI) begin
      sat_sum = HI[W_WIDTH-1:0];
    end else if (raw_sum < LO) begin
      sat_sum = LO[W_WIDTH-1:0];
    end else begin
      sat_sum = raw_sum[W_WIDTH-1:0];
    end
  end

endmodule

// File: rtl/spk_syn_sum.sv
module spk_syn_sum
  import spk_syn_pkg::*;
#(
  parameter int N_SYN       = DEF_SYN,
  parameter int W_WIDTH     = DEF_WIDTH,
  parameter int SYNC_STAGES = DEF_SYNC,
  localparam int ADDR_W     = addr_width(N_SYN)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_SYN-1:0]          spike_in,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [W_WIDTH-1:0]        wr_data,
  output logic signed [W_WIDTH-1:0] sum_out
);

  localparam int SUM_W = sum_width(N_SYN, W_WIDTH);

  logic [N_SYN*W_WIDTH-1:0] weight_flat;
  logic [N_SYN*W_WIDTH-1:0] contrib_flat;
  logic [N_SYN-1:0]         pending_vec;
  logic [N_SYN-1:0]         rise_vec;
  logic [N_SYN-1:0]         wr_sel;
  logic signed [SUM_W-1:0]  raw_sum;
  logic signed [W_WIDTH-1:0] sat_sum;
  logic signed [W_WIDTH-1:0] sum_q, sum_d;

  for (genvar i = 0; i < N_SYN; i++) begin : g_slot
    assign wr_sel[i] = wr_en && (wr_addr == ADDR_W'(i));

    spk_syn_slot #(
      .W_WIDTH    (W_WIDTH),
      .SYNC_STAGES(SYNC_STAGES)
    ) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .spike_async(spike_in[i]),
      .wr_sel     (wr_sel[i]),
      .wr_data    (wr_data),
      .weight_o   (weight_flat[i*W_WIDTH +: W_WIDTH]),
      .pending_o  (pending_vec[i]),
      .rise_o     (rise_vec[i]),
      .contrib_o  (contrib_flat[i*W_WIDTH +: W_WIDTH])
    );
  end

  spk_sat_sum #(
    .N_SYN  (N_SYN),
    .W_WIDTH(W_WIDTH),
    .SUM_W  (SUM_W)
  ) u_sum (
    .contrib_flat(contrib_flat),
    .raw_sum     (raw_sum),
    .sat_sum     (sat_sum)
  );

  // Soma-side sample of the summing node.
  always_comb begin
    sum_d = sat_sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
    end else begin
      sum_q <= sum_d;
    end
  end

  assign sum_out = sum_q;

endmodule

// File: rtl/spk_syn_sum_chk.sv
module spk_syn_sum_chk #(
  parameter int N_SYN   = 4,
  parameter int W_WIDTH = 6,
  parameter int SUM_W   = 9,
  parameter int ADDR_W  = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wr_en,
  input logic [ADDR_W-1:0]          wr_addr,
  input logic [W_WIDTH-1:0]         wr_data,
  input logic [N_SYN*W_WIDTH-1:0]   weight_flat,
  input logic [N_SYN-1:0]           pending_vec,
  input logic [N_SYN-1:0]           rise_vec,
  input logic signed [SUM_W-1:0]    raw_sum,
  input logic signed [W_WIDTH-1:0]  sum_out
);

  localparam logic signed [SUM_W-1:0]   HI   = SUM_W'((2 ** (W_WIDTH - 1)) - 1);
  localparam logic signed [SUM_W-1:0]   LO   = SUM_W'(-(2 ** (W_WIDTH - 1)));
  localparam logic signed [W_WIDTH-1:0] HI_W = HI[W_WIDTH-1:0];
  localparam logic signed [W_WIDTH-1:0] LO_W = LO[W_WIDTH-1:0];

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_zero_R1: assert (sum_out == '0)
        else $error("sum_out not zero during reset");
    end
  end

  for (genvar i = 0; i < N_SYN; i++) begin : g_wr
    assert_weight_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(i)) |=>
        weight_flat[i*W_WIDTH +: W_WIDTH] == $past(wr_data));
  end

  assert_one_shot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pending_vec & ~rise_vec) != '0) |=>
      ((pending_vec & $past(pending_vec & ~rise_vec)) == '0));

  assert_pass_through_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_sum <= HI && raw_sum >= LO) |=> sum_out == $past(raw_sum[W_WIDTH-1:0]));

  assert_sat_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_sum > HI) |=> sum_out == HI_W);

  assert_sat_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_sum < LO) |=> sum_out == LO_W);

  assert_no_retrigger_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_vec != '0) |=> ((rise_vec & $past(rise_vec)) == '0));

  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_vec == '0) |=> sum_out == '0);

endmodule

bind spk_syn_sum spk_syn_sum_chk #(
  .N_SYN  (N_SYN),
  .W_WIDTH(W_WIDTH),
  .SUM_W  (SUM_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .weight_flat(weight_flat),
  .pending_vec(pending_vec),
  .rise_vec   (rise_vec),
  .raw_sum    (raw_sum),
  .sum_out    (sum_q)
);

// File: tb/tb_spk_syn_sum.sv
`timescale 1ns/1ps
module tb_spk_syn_sum;

  localparam int NS = 4;
  localparam int WW = 6;

  typedef struct packed {
    logic [NS-1:0]        mask;
    logic signed [WW-1:0] exp;
  } vec_t;

  // Weights: s0=10, s1=-7, s2=25, s3=-32
  localparam vec_t VECS [12] = '{
    '{4'b0000, 6'sd0},
    '{4'b0001, 6'sd10},
    '{4'b0010, -6'sd7},
    '{4'b0011, 6'sd3},
    '{4'b0101, 6'sd31},
    '{4'b1000, 6'b100000},
    '{4'b1010, 6'b100000},
    '{4'b1111, -6'sd4},
    '{4'b1110, -6'sd14},
    '{4'b0110, 6'sd18},
    '{4'b0111, 6'sd28},
    '{4'b1101, 6'sd3}
  };

  logic                 clk;
  logic                 rst_n;
  logic [NS-1:0]        spike_in;
  logic                 wr_en;
  logic [1:0]           wr_addr;
  logic [WW-1:0]        wr_data;
  logic signed [WW-1:0] sum_out;

  int  n_checks;
  int  n_fails;
  bit  done;

  spk_syn_sum dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .spike_in(spike_in),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .sum_out (sum_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input int got, input int exp, input string req);
    n_checks++;
    if (got != exp) begin
      n_fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic write_w(input int addr, input int data);
    wr_en   = 1'b1;
    wr_addr = 2'(addr);
    wr_data = 6'(data);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  // Called at a negedge: one-cycle pulse, checks edges e2, e3, e4.
  task automatic pulse_check(input logic [NS-1:0] mask, input int exp, input string req);
    spike_in = mask;
    @(negedge clk);
    spike_in = '0;
    @(negedge clk);
    @(negedge clk);
    check(int'(sum_out), 0, "R3 latency e2");
    @(negedge clk);
    check(int'(sum_out), exp, req);
    @(negedge clk);
    check(int'(sum_out), 0, "R3 one cycle");
  endtask

  initial begin
    n_checks = 0;
    n_fails  = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    spike_in = '0;
    wr_en    = 1'b0;
    wr_addr  = '0;
    wr_data  = '0;
    repeat (3) @(negedge clk);
    check(int'(sum_out), 0, "R1 reset value");
    rst_n = 1'b1;
    @(negedge clk);
    check(int'(sum_out), 0, "R8 idle after reset");

    write_w(0, 10);
    write_w(1, -7);
    write_w(2, 25);
    write_w(3, -32);
    @(negedge clk);

    // Table walk: R2, R4, R5, R8
    for (int v = 0; v < 12; v++) begin
      pulse_check(VECS[v].mask, int'(VECS[v].exp), "R4/R5 table sum");
    end

    // R6: level held high fires once
    begin
      int hits;
      hits = 0;
      spike_in = 4'b0100;
      for (int k = 1; k <= 12; k++) begin
        @(negedge clk);
        if (k == 4) check(int'(sum_out), 25, "R6 held level event");
        if (sum_out != 0) hits++;
      end
      check(hits, 1, "R6 held level once");
      spike_in = '0;
      repeat (4) @(negedge clk);
    end

    // R6: one-cycle low re-arms
    begin
      int hits;
      hits = 0;
      spike_in = 4'b0001;
      for (int k = 1; k <= 14; k++) begin
        @(negedge clk);
        if (k == 3) spike_in = 4'b0000;
        if (k == 4) spike_in = 4'b0001;
        if (sum_out != 0) hits++;
      end
      check(hits, 2, "R6 re-arm after low");
      spike_in = '0;
      repeat (4) @(negedge clk);
    end

    // R7: staggered spikes land in successive samples
    spike_in = 4'b0001;
    @(negedge clk);
    spike_in = 4'b0100;
    @(negedge clk);
    spike_in = 4'b0000;
    @(negedge clk);
    @(negedge clk);
    check(int'(sum_out), 10, "R7 first sample");
    @(negedge clk);
    check(int'(sum_out), 25, "R7 second sample");
    @(negedge clk);
    check(int'(sum_out), 0, "R7 then idle");

    // R2: rewrite one weight, neighbours unchanged
    write_w(1, -1);
    write_w(3, 5);
    @(negedge clk);
    pulse_check(4'b0010, -1, "R2 new weight s1");
    pulse_check(4'b1000, 5, "R2 new weight s3");
    pulse_check(4'b0001, 10, "R2 s0 untouched");

    // R1: reset drops a pending event, weights survive
    spike_in = 4'b0001;
    @(negedge clk);
    spike_in = '0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(int'(sum_out), 0, "R1 zero in reset");
    rst_n = 1'b1;
    begin
      int hits;
      hits = 0;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        if (sum_out != 0) hits++;
      end
      check(hits, 0, "R1 pending dropped");
    end
    pulse_check(4'b0001, 10, "R1 weight kept");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule